// File: doc/BRIEF.md
# Register Shift and Rotate Unit

This block is the purely combinational shift datapath of a 32-bit integer execution stage. From the function code, one rotate-select bit, the 5-bit immediate amount and the two source operands it produces a 32-bit result in the same cycle. It is placed beside the adder in the execute stage. The upstream decoder routes the correct instruction bit into the rotate-select input. For immediate-amount encodings that is instruction bit 21; for variable-amount encodings it is bit 6.

The unit handles eight operations. Logical left shift, logical right shift and arithmetic right shift each exist in an immediate form and a variable form. Rotate right also exists in both forms, and it reuses the logical-right function codes with rotate-select set. Variable forms take their amount from the low five bits of the `rs` operand. A `valid` flag reports whether the encoding was recognised. An all-zero encoding, the usual no-operation pattern, is just a left shift by zero and yields zero.

Top module: `shift_unit`

## Requirements
- R1: Function code 0x00 with rotate-select 0 gives `rt` shifted left logically by `sa`, and `valid` is 1.
- R2: Function code 0x02 with rotate-select 0 gives `rt` shifted right logically by `sa`, zero-filled.
- R3: Function code 0x02 with rotate-select 1 gives `rt` rotated right by `sa`, equal to (rt >> n) | (rt << (32-n)) for n > 0.
- R4: Function code 0x03 with rotate-select 0 gives `rt` shifted right arithmetically by `sa`, filling with bit 31 of `rt`.
- R5: Function code 0x04 with rotate-select 0 gives `rt` shifted left logically by `rs[4:0]`.
- R6: Function code 0x06 gives `rt` shifted right logically by `rs[4:0]` when rotate-select is 0, and rotated right by `rs[4:0]` when it is 1.
- R7: Function code 0x07 with rotate-select 0 gives `rt` shifted right arithmetically by `rs[4:0]`.
- R8: A rotate by an amount of zero returns `rt` unchanged, in both the immediate and the variable form.
- R9: Any function code other than 0x00, 0x02, 0x03, 0x04, 0x06 or 0x07 drives `valid` to 0 and the result to zero. So does rotate-select 1 on codes 0x00, 0x03, 0x04 or 0x07.
- R10: Variable forms ignore `sa` and `rs[31:5]`, and immediate forms ignore `rs` entirely.
- R11: With all inputs zero (the no-operation encoding) the result is zero and `valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| funct_i | input | 6 | Function code of the register-format instruction |
| rot_sel_i | input | 1 | Rotate-select bit (bit 21 for immediate forms, bit 6 for variable forms) |
| sa_i | input | 5 | Immediate shift amount |
| rs_i | input | 32 | First source operand; low five bits are the variable amount |
| rt_i | input | 32 | Operand being shifted |
| result_o | output | 32 | Shift or rotate result, zero when invalid |
| valid_o | output | 1 | High when the encoding is a recognised shift |

## Verification
The checker evaluates its properties only when every input is a known value. It also assumes the rotate-select input already carries the correct instruction bit for the form being decoded. The bench therefore drives fully defined inputs at every step. It covers every amount from 0 to 31 with random operands for each of the eight operations, places random junk in the fields each form must ignore, and sweeps all 64 function codes with both rotate-select values to probe the invalid space.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FN_W   = 6;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } fill_e;

  localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
  localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
  localparam logic [FN_W-1:0] FN_SRAV = 6'h07;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
(
  input  logic [FN_W-1:0] funct_i,
  input  logic            rot_sel_i,
  output logic            valid_o,
  output logic            left_o,
  output logic            use_var_o,
  output fill_e           fill_o
);
  always_comb begin
    valid_o   = 1'b0;
    left_o    = 1'b0;
    use_var_o = 1'b0;
    fill_o    = FILL_ZERO;
    unique case (funct_i)
      FN_SLL, FN_SLLV: begin
        valid_o   = !rot_sel_i;
        left_o    = 1'b1;
        use_var_o = (funct_i == FN_SLLV);
      end
      FN_SRL, FN_SRLV: begin
        valid_o   = 1'b1;
        use_var_o = (funct_i == FN_SRLV);
        fill_o    = rot_sel_i ? FILL_WRAP : FILL_ZERO;
      end
      FN_SRA, FN_SRAV: begin
        valid_o   = !rot_sel_i;
        use_var_o = (funct_i == FN_SRAV);
        fill_o    = FILL_SIGN;
      end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel
  import shift_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             left_i,
  input  fill_e            fill_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] rev_in;
  logic [WIDTH-1:0] stg [AMT_W+1];
  logic [WIDTH-1:0] rev_out;

  // Left shifts become right shifts of the bit-reversed operand.
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev_in[i]  = data_i[WIDTH-1-i];
    assign rev_out[i] = stg[AMT_W][WIDTH-1-i];
  end

  assign stg[0] = left_i ? rev_in : data_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    logic [S-1:0] fill_bits;
    always_comb begin
      unique case (fill_i)
        FILL_SIGN: fill_bits = {S{stg[k][WIDTH-1]}};
        FILL_WRAP: fill_bits = stg[k][S-1:0];
        default:   fill_bits = '0;
      endcase
    end
    assign stg[k+1] = amt_i[k] ? {fill_bits, stg[k][WIDTH-1:S]} : stg[k];
  end

  assign data_o = left_i ? rev_out : stg[AMT_W];
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
(
  input  logic [5:0]  funct_i,
  input  logic        rot_sel_i,
  input  logic [4:0]  sa_i,
  input  logic [31:0] rs_i,
  input  logic [31:0] rt_i,
  output logic [31:0] result_o,
  output logic        valid_o
);
  localparam int unsigned AMT_W = $clog2(DATA_W);

  logic             dec_valid;
  logic             dec_left;
  logic             dec_var;
  fill_e            dec_fill;
  logic [AMT_W-1:0] amount;
  logic [DATA_W-1:0] shifted;

  shift_decode u_decode (
    .funct_i   (funct_i),
    .rot_sel_i (rot_sel_i),
    .valid_o   (dec_valid),
    .left_o    (dec_left),
    .use_var_o (dec_var),
    .fill_o    (dec_fill)
  );

  assign amount = dec_var ? rs_i[AMT_W-1:0] : sa_i;

  shift_barrel #(.WIDTH(DATA_W)) u_barrel (
    .data_i (rt_i),
    .amt_i  (amount),
    .left_i (dec_left),
    .fill_i (dec_fill),
    .data_o (shifted)
  );

  assign valid_o  = dec_valid;
  assign result_o = dec_valid ? shifted : '0;
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk (
  input logic [5:0]  funct_i,
  input logic        rot_sel_i,
  input logic [4:0]  sa_i,
  input logic [31:0] rs_i,
  input logic [31:0] rt_i,
  input logic [31:0] result_o,
  input logic        valid_o
);
  logic [4:0] amt;
  logic       is_rot;

  always_comb begin
    amt    = funct_i[2] ? rs_i[4:0] : sa_i;
    is_rot = rot_sel_i && (funct_i == 6'h02 || funct_i == 6'h06);
    if (!$isunknown({funct_i, rot_sel_i, sa_i, rs_i, rt_i})) begin
      if (!valid_o) begin
        assert_invalid_zero_R9: assert (result_o == 32'h0);
      end
      if (is_rot && amt == 5'd0) begin
        assert_rot_zero_identity_R8: assert (result_o == rt_i);
      end
      if (is_rot) begin
        assert_rot_keeps_ones_R3: assert ($countones(result_o) == $countones(rt_i));
      end
      if (funct_i == 6'h00 && !rot_sel_i) begin
        assert_sll_low_clear_R1: assert ((result_o & ((32'h1 << sa_i) - 32'h1)) == 32'h0);
      end
      if (funct_i == 6'h03 && !rot_sel_i) begin
        assert_sra_sign_kept_R4: assert (result_o[31] == rt_i[31]);
      end
      if (funct_i == 6'h00 && !rot_sel_i) begin
        assert_nop_valid_R11: assert (valid_o);
      end
    end
  end
endmodule

bind shift_unit shift_unit_chk u_chk (
  .funct_i   (funct_i),
  .rot_sel_i (rot_sel_i),
  .sa_i      (sa_i),
  .rs_i      (rs_i),
  .rt_i      (rt_i),
  .result_o  (result_o),
  .valid_o   (valid_o)
);

// File: tb/shift_unit_tb_top.sv
module shift_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic [5:0]  funct;
  logic        rot_sel;
  logic [4:0]  sa;
  logic [31:0] rs;
  logic [31:0] rt;
  logic [31:0] result;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  shift_unit dut_i (
    .funct_i   (funct),
    .rot_sel_i (rot_sel),
    .sa_i      (sa),
    .rs_i      (rs),
    .rt_i      (rt),
    .result_o  (result),
    .valid_o   (valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] ror(input logic [31:0] v, input int n);
    if (n == 0) return v;
    return (v >> n) | (v << (32 - n));
  endfunction

  task automatic apply(input logic [5:0] f, input logic r, input logic [4:0] s,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic ev, input logic [31:0] er, input string tag);
    @(negedge clk);
    funct = f; rot_sel = r; sa = s; rs = a; rt = b;
    #2;
    checks++;
    if (valid !== ev || result !== er) begin
      errors++;
      $display("FAIL %s: funct=%h rot=%0b sa=%0d rs=%h rt=%h got valid=%0b result=%h exp valid=%0b result=%h",
               tag, f, r, s, a, b, valid, result, ev, er);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; funct = '0; rot_sel = 0; sa = '0; rs = '0; rt = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset-like all-zero encoding
    apply(6'h00, 0, 5'd0, 32'h0, 32'h0, 1, 32'h0, "R11 nop");
    apply(6'h02, 1, 5'd0, 32'h0, 32'hA5A5_0F0F, 1, 32'hA5A5_0F0F, "R8 rotr by zero");
    apply(6'h06, 1, 5'd7, 32'hFFFF_FFE0, 32'h1234_5678, 1, 32'h1234_5678, "R8 rotrv by zero");
    for (int n = 0; n < 32; n++) begin
      for (int k = 0; k < 6; k++) begin
        logic [31:0] b, junk, a;
        logic [4:0]  js;
        b    = (k == 0) ? 32'h8000_0001 : (k == 1) ? 32'hFFFF_FFFF : $urandom();
        junk = $urandom();
        js   = 5'($urandom());
        a    = {junk[31:5], 5'(n)};
        apply(6'h00, 0, 5'(n), junk, b, 1, b << n, "R1 sll");
        apply(6'h02, 0, 5'(n), junk, b, 1, b >> n, "R2 srl");
        apply(6'h02, 1, 5'(n), junk, b, 1, ror(b, n), "R3 rotr");
        apply(6'h03, 0, 5'(n), junk, b, 1, 32'($signed(b) >>> n), "R4 sra");
        apply(6'h04, 0, js, a, b, 1, b << n, "R5 sllv R10");
        apply(6'h06, 0, js, a, b, 1, b >> n, "R6 srlv R10");
        apply(6'h06, 1, js, a, b, 1, ror(b, n), "R6 rotrv R10");
        apply(6'h07, 0, js, a, b, 1, 32'($signed(b) >>> n), "R7 srav R10");
      end
    end
    // R9: sweep every function code and rotate-select value
    for (int f = 0; f < 64; f++) begin
      for (int r = 0; r < 2; r++) begin
        bit ok;
        logic [31:0] b;
        b  = $urandom() | 32'h1;
        ok = (f == 2 || f == 6) || ((f == 0 || f == 3 || f == 4 || f == 7) && r == 0);
        if (!ok) apply(6'(f), 1'(r), 5'd3, 32'h3, b, 0, 32'h0, "R9 invalid");
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule